// File: doc/BRIEF.md
# NTSC Scan-Line Tracker with Caption Gate

This block follows the digital composite-sync and vertical-sync levels produced by an external video sync separator and keeps a running count of the current NTSC scan line and field. Every falling edge of composite sync is a candidate line start. A lockout timer rejects the extra half-line edges of the vertical interval, so that each line advances the count at most once. When vertical sync goes low, the counter is loaded with a preset value. That preset edge falls mid-line, which is why the loaded value is not zero. Whether the preset edge arrived inside the lockout window decides which field has started.

Every accepted line receives a back-porch clamp pulse of fixed width, used to restore the DC level of the analog front end. On the caption line, the clamp is suppressed and a data-sampling window opens instead, together with a one-cycle marker. A downstream slicer uses the field flag to choose between the two sets of caption channels. If sync edges stop arriving, the block flags the loss of sync and keeps every timed output quiet until the next vertical preset. All timing values are parameters in clock cycles. The defaults suit a 27 MHz clock: about 1716 clocks per line, a 40 us lockout and a 2.0 us clamp placed late enough to cover separator and filter delay.

Top module: `ntsc_line_tracker`

## Requirements
- R1: After reset, line_num is 0, field_odd is 0, clamp, sample_window and line21_strobe are 0, and sync_lost is 1.
- R2: A falling edge of csync_n is accepted when more than LOCKOUT clock cycles have passed since the previous accepted or preset edge, with spacing measured edge to edge in clock cycles. An accepted edge raises line_num by one.
- R3: A falling edge of csync_n that arrives no more than LOCKOUT cycles after the previous accepted or preset edge is ignored. It changes neither line_num nor the timing of clamp or sample_window.
- R4: The first csync_n falling edge seen with vsync_n low, after vsync_n has been high, is a preset edge. If it arrives within the lockout, line_num loads PRESET_ODD and field_odd becomes 1. Otherwise line_num loads PRESET_EVEN and field_odd becomes 0. Further edges while vsync_n stays low are counted normally, and field_odd changes only at a preset edge.
- R5: Rising clock edge 0 is the first one that samples csync_n low. For an accepted edge on any line other than CAP_LINE, clamp is 1 after rising edges CLAMP_DLY+3 through CLAMP_DLY+CLAMP_LEN+2, and 0 otherwise.
- R6: No clamp pulse is produced on line CAP_LINE, and clamp and sample_window are never high together.
- R7: For an accepted edge that brings line_num to CAP_LINE, sample_window is 1 after rising edges WIN_START+3 through WIN_START+WIN_LEN+2, with the same numbering as R5, and 0 on all other lines.
- R8: line21_strobe is 1 for exactly the one cycle after rising edge 2 of an accepted edge that brings line_num to CAP_LINE.
- R9: line_num stops at LINE_MAX and does not wrap.
- R10: If no edge is accepted or preset for more than LOS_LIMIT cycles, sync_lost becomes 1. While sync_lost is 1, accepted edges still count, but clamp, sample_window and line21_strobe stay 0. Only a preset edge clears sync_lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Composite sync from the separator, low during sync tips, asynchronous |
| vsync_n | input | 1 | Vertical sync from the separator, low during the vertical pulse, asynchronous |
| line_num | output | $clog2(LINE_MAX+1) | Current scan line count |
| field_odd | output | 1 | 1 in the field carrying caption channels 1-2, 0 in the field carrying channels 3-4 and extended data |
| clamp | output | 1 | DC-restore pulse |
| sample_window | output | 1 | Caption data sampling window on the caption line |
| line21_strobe | output | 1 | One-cycle marker at the start of the caption line |
| sync_lost | output | 1 | Sync edges missing for longer than LOS_LIMIT cycles |

## Verification
The bench places edges exactly at the lockout boundary, one cycle on either side. A design with an off-by-one lockout compare would count a half-line pulse or drop a real line, and every later line number would shift. It drives a preset edge inside and outside the lockout and holds vsync_n low over several lines. A tracker that re-preset on a level or mixed up the field test would report the wrong field or never pass line 21. Random half-line edges are placed inside running clamp and caption windows, so a design that restarted its pulse timer on ignored edges would show a shifted clamp. A long gap then checks that the timed outputs stay quiet while sync is lost and come back only after a preset.

// File: rtl/ntsc_trk_pkg.sv
package ntsc_trk_pkg;

   // registered line events handed from the counter to the pulse timer
   typedef struct packed {
      logic accept;
      logic preset;
   } trk_evt_t;

   // bits needed to hold values 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] lvl_d
);

   // one synchronizer chain per input bit, plus one flop for edge detection
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-1:0], din[b]};
      end
      assign lvl[b]   = sh[STAGES-1];
      assign lvl_d[b] = sh[STAGES];
   end

endmodule

// File: rtl/trk_linectr.sv
module trk_linectr
   import ntsc_trk_pkg::*;
#(
   parameter int LOCKOUT     = 1080,
   parameter int LOS_LIMIT   = 2574,
   parameter int LINE_MAX    = 525,
   parameter int PRESET_ODD  = 4,
   parameter int PRESET_EVEN = 3,
   parameter int LW          = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall,
   input  logic          vs_lvl,
   output logic [LW-1:0] line_num,
   output logic          field_odd,
   output logic          lost,
   output trk_evt_t      evt
);

   localparam int SW = cnt_w(LOS_LIMIT);

   logic [SW-1:0] since;
   logic          armed;
   logic          lock_open;
   logic          do_preset;
   logic          do_accept;

   assign lock_open = (since >= SW'(LOCKOUT));
   assign do_preset = fall && !vs_lvl && armed;
   assign do_accept = fall && !do_preset && lock_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since     <= SW'(LOS_LIMIT);
         armed     <= 1'b0;
         line_num  <= '0;
         field_odd <= 1'b0;
         lost      <= 1'b1;
         evt       <= '0;
      end else begin
         evt.accept <= do_accept;
         evt.preset <= do_preset;

         if (do_preset || do_accept)      since <= '0;
         else if (since != SW'(LOS_LIMIT)) since <= since + 1'b1;

         if (do_preset)   armed <= 1'b0;
         else if (vs_lvl) armed <= 1'b1;

         if (do_preset) begin
            field_odd <= !lock_open;
            line_num  <= lock_open ? LW'(PRESET_EVEN) : LW'(PRESET_ODD);
            lost      <= 1'b0;
         end else if (do_accept) begin
            if (line_num < LW'(LINE_MAX)) line_num <= line_num + 1'b1;
         end else if (since >= SW'(LOS_LIMIT - 1)) begin
            lost <= 1'b1;
         end
      end
   end

   AST_LINE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      line_num <= LW'(LINE_MAX)); // R9

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.preset && line_num != $past(line_num)) |-> (line_num == $past(line_num) + 1'b1)); // R2

   AST_FIELD_AT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (field_odd != $past(field_odd)) |-> evt.preset); // R4

   AST_LOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lost) |-> evt.preset); // R10

endmodule

// File: rtl/trk_pulse.sv
module trk_pulse
   import ntsc_trk_pkg::*;
#(
   parameter int CLAMP_DLY = 150,
   parameter int CLAMP_LEN = 54,
   parameter int WIN_START = 280,
   parameter int WIN_LEN   = 760,
   parameter int CAP_LINE  = 21,
   parameter int LW        = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          lost,
   input  logic [LW-1:0] line_num,
   output logic          clamp,
   output logic          sample_window,
   output logic          line21_strobe
);

   localparam int CLAMP_END = CLAMP_DLY + CLAMP_LEN;
   localparam int WIN_END   = WIN_START + WIN_LEN;
   localparam int PH_MAX    = max2(CLAMP_END, WIN_END);
   localparam int PW        = cnt_w(PH_MAX);

   logic [PW-1:0] ph;
   logic          on_cap;

   assign on_cap = (line_num == LW'(CAP_LINE));

   // phase since the last accepted edge, parked at PH_MAX where nothing fires
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ph <= PW'(PH_MAX);
      else if (accept)              ph <= '0;
      else if (ph != PW'(PH_MAX))   ph <= ph + 1'b1;
   end

   assign clamp = !lost && !on_cap &&
                  (ph >= PW'(CLAMP_DLY)) && (ph < PW'(CLAMP_END));

   if (WIN_LEN > 0) begin : g_win
      assign sample_window = !lost && on_cap &&
                             (ph >= PW'(WIN_START)) && (ph < PW'(WIN_END));
      assign line21_strobe = !lost && on_cap && accept;
   end else begin : g_nowin
      assign sample_window = 1'b0;
      assign line21_strobe = 1'b0;
   end

   AST_CLAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp) |=> clamp); // R5

   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      line21_strobe |=> !line21_strobe); // R8

endmodule

// File: rtl/ntsc_line_tracker.sv
module ntsc_line_tracker
   import ntsc_trk_pkg::*;
#(
   parameter int LOCKOUT     = 1080,
   parameter int LOS_LIMIT   = 2574,
   parameter int CLAMP_DLY   = 150,
   parameter int CLAMP_LEN   = 54,
   parameter int WIN_START   = 280,
   parameter int WIN_LEN     = 760,
   parameter int CAP_LINE    = 21,
   parameter int PRESET_ODD  = 4,
   parameter int PRESET_EVEN = 3,
   parameter int LINE_MAX    = 525,
   parameter int SYNC_STAGES = 2,
   localparam int LW         = cnt_w(LINE_MAX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csync_n,
   input  logic          vsync_n,
   output logic [LW-1:0] line_num,
   output logic          field_odd,
   output logic          clamp,
   output logic          sample_window,
   output logic          line21_strobe,
   output logic          sync_lost
);

   // elaboration-time parameter checks
   if (LOCKOUT < 1 || LOCKOUT >= LOS_LIMIT) begin : g_chk_lock
      $error("lockout must lie between 1 and the loss limit");
   end
   if (CLAMP_LEN < 2 || CLAMP_DLY + CLAMP_LEN > LOCKOUT) begin : g_chk_clamp
      $error("clamp pulse must be at least 2 cycles and end inside the lockout");
   end
   if (WIN_START < 1 || WIN_START + WIN_LEN > LOCKOUT) begin : g_chk_win
      $error("sampling window must start after the strobe and end inside the lockout");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("at least two synchronizer stages are required");
   end
   if (CAP_LINE > LINE_MAX || PRESET_ODD > LINE_MAX || PRESET_EVEN > LINE_MAX) begin : g_chk_line
      $error("line constants exceed LINE_MAX");
   end

   logic [1:0] s_lvl;
   logic [1:0] s_lvl_d;
   logic       cs_fall;
   logic       lost;
   trk_evt_t   evt;

   trk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({vsync_n, csync_n}),
      .lvl   (s_lvl),
      .lvl_d (s_lvl_d)
   );

   assign cs_fall = s_lvl_d[0] && !s_lvl[0];

   trk_linectr #(
      .LOCKOUT     (LOCKOUT),
      .LOS_LIMIT   (LOS_LIMIT),
      .LINE_MAX    (LINE_MAX),
      .PRESET_ODD  (PRESET_ODD),
      .PRESET_EVEN (PRESET_EVEN),
      .LW          (LW)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (cs_fall),
      .vs_lvl    (s_lvl[1]),
      .line_num  (line_num),
      .field_odd (field_odd),
      .lost      (lost),
      .evt       (evt)
   );

   trk_pulse #(
      .CLAMP_DLY (CLAMP_DLY),
      .CLAMP_LEN (CLAMP_LEN),
      .WIN_START (WIN_START),
      .WIN_LEN   (WIN_LEN),
      .CAP_LINE  (CAP_LINE),
      .LW        (LW)
   ) u_pulse (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept        (evt.accept),
      .lost          (lost),
      .line_num      (line_num),
      .clamp         (clamp),
      .sample_window (sample_window),
      .line21_strobe (line21_strobe)
   );

   assign sync_lost = lost;

   AST_CLAMP_WIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(clamp && sample_window)); // R6

   AST_STROBE_BEFORE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      line21_strobe |=> !sample_window); // R8

   AST_WIN_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_window |-> $stable(line_num)); // R7

   AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |-> !(clamp || sample_window || line21_strobe)); // R10

endmodule

// File: tb/sim_ntsc_line_tracker.sv
module sim_ntsc_line_tracker;

   localparam int CLK_NS   = 10;
   localparam int LOCKOUT  = 60;
   localparam int LOS      = 150;
   localparam int CD       = 10;
   localparam int CL       = 8;
   localparam int WS       = 25;
   localparam int WL       = 30;
   localparam int CAP      = 21;
   localparam int P_ODD    = 4;
   localparam int P_EVEN   = 3;
   localparam int LMAX     = 40;
   localparam int LW       = $clog2(LMAX + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csync_n = 1'b1;
   logic          vsync_n = 1'b1;
   logic [LW-1:0] line_num;
   logic          field_odd, clamp, sample_window, line21_strobe, sync_lost;

   ntsc_line_tracker #(
      .LOCKOUT (LOCKOUT), .LOS_LIMIT (LOS), .CLAMP_DLY (CD), .CLAMP_LEN (CL),
      .WIN_START (WS), .WIN_LEN (WL), .CAP_LINE (CAP), .PRESET_ODD (P_ODD),
      .PRESET_EVEN (P_EVEN), .LINE_MAX (LMAX), .SYNC_STAGES (2)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .csync_n (csync_n), .vsync_n (vsync_n),
      .line_num (line_num), .field_odd (field_odd), .clamp (clamp),
      .sample_window (sample_window), .line21_strobe (line21_strobe),
      .sync_lost (sync_lost)
   );

   always #(CLK_NS/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   int cur_t = 0;
   int ev_t = -100000;
   int acc_t = -100000;
   int acc_line = 0;
   bit acc_lost = 1'b1;
   int m_line = 0;
   bit m_field = 1'b0;
   bit m_lost = 1'b1;
   bit m_armed = 1'b0;
   bit vs_cur = 1'b1;
   int low_left = 0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s t=%0d actual=%0d expected=%0d", req, cur_t, act, exp);
      end
   endtask

   // advance one cycle, compare the timed outputs at the falling clock edge
   task automatic step();
      int k;
      bit e_clamp, e_win, e_strb;
      @(negedge clk);
      cur_t++;
      k = cur_t - acc_t;
      e_clamp = !acc_lost && acc_line != CAP && k >= CD + 4 && k < CD + 4 + CL;
      e_win   = !acc_lost && acc_line == CAP && k >= WS + 4 && k < WS + 4 + WL;
      e_strb  = !acc_lost && acc_line == CAP && k == 3;
      check(acc_lost ? "R10 clamp" : (acc_line == CAP ? "R6 clamp" : "R5 clamp"),
            int'(clamp), int'(e_clamp));
      check(acc_lost ? "R10 window" : "R7 window", int'(sample_window), int'(e_win));
      check(acc_lost ? "R10 strobe" : "R8 strobe", int'(line21_strobe), int'(e_strb));
      if (low_left > 0) begin
         low_left--;
         if (low_left == 0) csync_n = 1'b1;
      end
   endtask

   // drive one csync falling edge with the given vsync level, then hold
   task automatic edge_ev(input bit v, input int hold);
      int gap;
      gap = cur_t - ev_t;
      if (gap > LOS) m_lost = 1'b1;
      check("R2 R3 R9 line", int'(line_num), m_line);
      check("R4 field", int'(field_odd), int'(m_field));
      check("R10 lost", int'(sync_lost), int'(m_lost));
      if (vs_cur) m_armed = 1'b1;
      vs_cur = v;
      vsync_n = v;
      csync_n = 1'b0;
      low_left = 4;
      if (!v && m_armed) begin
         m_field = (gap - 1 < LOCKOUT);
         m_line = m_field ? P_ODD : P_EVEN;
         m_lost = 1'b0;
         m_armed = 1'b0;
         ev_t = cur_t;
      end else if (gap - 1 >= LOCKOUT) begin
         if (m_line < LMAX) m_line++;
         ev_t = cur_t;
         acc_t = cur_t;
         acc_line = m_line;
         acc_lost = m_lost;
      end
      repeat (hold) step();
   endtask

   // one randomly timed line, sometimes with a half-line edge inside it
   task automatic rand_line();
      int len, h;
      len = LOCKOUT + 1 + int'($urandom % (LOS - LOCKOUT));
      if ($urandom % 2 == 1) begin
         h = 20 + int'($urandom % (LOCKOUT - 19));
         edge_ev(1'b1, h);
         edge_ev(1'b1, len - h);   // ignored edge, R3
      end else begin
         edge_ev(1'b1, len);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_bad++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1871));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 line", int'(line_num), 0);
      check("R1 field", int'(field_odd), 0);
      check("R1 clamp", int'(clamp), 0);
      check("R1 window", int'(sample_window), 0);
      check("R1 strobe", int'(line21_strobe), 0);
      check("R1 lost", int'(sync_lost), 1);
      repeat (300) step();

      // lines before any preset: counted, but quiet (R10)
      repeat (3) edge_ev(1'b1, 80);

      // odd preset: vsync edge half a line after an accepted edge (R4)
      edge_ev(1'b1, 50);
      edge_ev(1'b0, 80);
      edge_ev(1'b0, 80);          // vsync still low: counted, no re-preset
      // lockout boundary (R2, R3)
      edge_ev(1'b1, LOCKOUT);
      edge_ev(1'b1, LOCKOUT + 1); // spacing equals LOCKOUT: ignored
      edge_ev(1'b1, LOS);         // spacing LOCKOUT+1 after ignore: accepted
      edge_ev(1'b1, 80);          // spacing LOS: accepted, no loss

      // random lines through the caption line up to saturation (R5-R9)
      repeat (45) rand_line();

      // even preset: vsync edge outside the lockout (R4)
      edge_ev(1'b1, 80);
      edge_ev(1'b0, 80);
      repeat (25) rand_line();

      // loss of sync and recovery (R10)
      edge_ev(1'b1, LOS + 40);
      edge_ev(1'b1, 80);
      edge_ev(1'b1, 80);
      edge_ev(1'b0, 80);
      repeat (20) rand_line();

      edge_ev(1'b1, 100);
      check("R2 final line", int'(line_num), m_line);
      finish_run();
   end

endmodule